// File: doc/BRIEF.md
# Two-by-Two Integer Matrix Multiplier with Scalar Broadcast

This block computes C = A × B for two 2×2 signed integer matrices. It does not form each result element as its own dot product. It keeps one two-lane accumulator for each column of C. In step k the engine takes column k of A as a two-lane vector. It copies the scalar B(k,1) into both lanes of the first multiplier and B(k,2) into both lanes of the second. It multiplies lane by lane and adds the products into the matching accumulator. After the final step, each accumulator column is copied into the output register.

A single-cycle start pulse begins a computation, and the engine latches both operand matrices in that cycle. Every matrix on the ports is packed in column-major order. A one-cycle done pulse marks the point where the result register holds the new product. The result register keeps that value until the next computation completes.

Top module: `mm2_bcast_engine`

## Requirements
- R1: Every matrix port is column-major. Element index 0 is (row 1, col 1), index 1 is (row 2, col 1), index 2 is (row 1, col 2) and index 3 is (row 2, col 2). Element i of an operand occupies bits [16i+15:16i], and element i of the result occupies bits [34i+33:34i].
- R2: Both accumulators restart from zero on every accepted start, so a result never depends on an earlier computation.
- R3: Each result element equals A(i,1)·B(1,j) + A(i,2)·B(2,j). Operands are 16-bit two's complement and results are 34-bit two's complement, exact for every operand value. The engine performs exactly two multiply-accumulate steps.
- R4: done is high for exactly one cycle. If start is sampled high while the engine is idle at rising edge E, done is high during the cycle that follows rising edge E+3, and low at every other time.
- R5: A start sampled while a computation is in progress (at edges E+1, E+2 or E+3) is ignored. It produces no extra done pulse and no change to the result.
- R6: The operands are taken from the ports at the edge that accepts start. Later changes on the operand ports do not affect that computation.
- R7: After synchronous active-high reset, done is low and all four result elements read zero.
- R8: A = identity and B with (1,1)=1, (2,1)=2, (1,2)=3, (2,2)=4 gives a result packed as 1, 2, 3, 4.
- R9: The result outputs keep their value between done pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation; accepted only when idle |
| a_flat | input | 64 | Matrix A, four signed 16-bit elements, column-major |
| b_flat | input | 64 | Matrix B, four signed 16-bit elements, column-major |
| c_flat | output | 136 | Product C, four signed 34-bit elements, column-major |
| done | output | 1 | One-cycle pulse when c_flat holds a new result |

## Verification
The bench sweeps one-hot placements of a nonzero element in A and another in B. A design that swaps rows for columns, or that broadcasts from the wrong element of B, puts the product in the wrong output slot. Operands at the signed extremes (all -32768, and mixes with 32767) catch a design that drops the sign extension or truncates the accumulator, which would show up as a wrapped or unsigned result. Some runs raise start again and invert the operand ports in the middle of a computation. A design that restarts there, or that reads the live ports, gives an extra or late done pulse or a corrupted product. Back-to-back runs expose accumulators that are not cleared, because the previous product would leak into the next result.

// File: rtl/mm2_pkg.sv
package mm2_pkg;
    parameter int DIM    = 2;
    parameter int ELEM_W = 16;

    localparam int CELLS  = DIM * DIM;
    localparam int PROD_W = 2 * ELEM_W;
    localparam int ACC_W  = PROD_W + $clog2(DIM) + 1;
    localparam int K_W    = (DIM > 1) ? $clog2(DIM) : 1;

    typedef logic signed [ELEM_W-1:0] elem_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIN
    } phase_e;

    typedef struct packed {
        logic           load;
        logic           step;
        logic           fin;
        logic [K_W-1:0] k;
    } ctrl_t;

    // column-major position of (row, col), both zero-based
    function automatic int cm_idx(input int row, input int col);
        return col * DIM + row;
    endfunction

    function automatic acc_t widen(input prod_t p);
        return acc_t'(p);
    endfunction
endpackage

// File: rtl/mm2_seq.sv
module mm2_seq
    import mm2_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    output ctrl_t ctrl
);
    phase_e         phase;
    logic [K_W-1:0] k_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= ST_IDLE;
            k_q   <= '0;
        end else begin
            case (phase)
                ST_IDLE: if (start) begin
                    phase <= ST_RUN;
                    k_q   <= '0;
                end
                ST_RUN: begin
                    if (k_q == K_W'(DIM - 1)) phase <= ST_FIN;
                    else                      k_q   <= k_q + 1'b1;
                end
                ST_FIN:  phase <= ST_IDLE;
                default: phase <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctrl.load = (phase == ST_IDLE) && start;
        ctrl.step = (phase == ST_RUN);
        ctrl.fin  = (phase == ST_FIN);
        ctrl.k    = k_q;
    end

    // R3: the last step hands over to the result write
    assert_two_steps_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_RUN && k_q == K_W'(DIM - 1)) |=> (phase == ST_FIN));

    // R5: no fresh first step can begin straight out of a busy phase
    assert_start_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (phase != ST_IDLE) |=> !(phase == ST_RUN && k_q == '0));
endmodule

// File: rtl/mm2_operand_sel.sv
module mm2_operand_sel
    import mm2_pkg::*;
(
    input  logic [CELLS-1:0][ELEM_W-1:0] a_m,
    input  logic [CELLS-1:0][ELEM_W-1:0] b_m,
    input  logic [K_W-1:0]               k,
    output logic [DIM-1:0][ELEM_W-1:0]   a_col,
    output logic [DIM-1:0][ELEM_W-1:0]   b_bc
);
    always_comb begin
        for (int r = 0; r < DIM; r++) begin
            a_col[r] = a_m[cm_idx(r, int'(k))];
        end
        for (int j = 0; j < DIM; j++) begin
            b_bc[j] = b_m[cm_idx(int'(k), j)];
        end
    end
endmodule

// File: rtl/mm2_lane_mac.sv
module mm2_lane_mac
    import mm2_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clear,
    input  logic                       en,
    input  logic [DIM-1:0][ELEM_W-1:0] vec,
    input  elem_t                      bscal,
    output logic [DIM-1:0][ACC_W-1:0]  acc
);
    for (genvar l = 0; l < DIM; l++) begin : g_lane
        prod_t p;
        acc_t  r;

        assign p = $signed(vec[l]) * bscal;

        always_ff @(posedge clk) begin
            if (rst || clear) r <= '0;
            else if (en)      r <= r + widen(p);
        end

        assign acc[l] = r;

        // R2: a cleared lane starts from zero
        assert_lane_clear_R2: assert property (@(posedge clk) disable iff (rst)
            clear |=> (r == '0));
    end
endmodule

// File: rtl/mm2_bcast_engine.sv
module mm2_bcast_engine
    import mm2_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [CELLS*ELEM_W-1:0]   a_flat,
    input  logic [CELLS*ELEM_W-1:0]   b_flat,
    output logic [CELLS*ACC_W-1:0]    c_flat,
    output logic                      done
);
    ctrl_t                              ctrl;
    logic [CELLS-1:0][ELEM_W-1:0]       a_q, b_q;
    logic [DIM-1:0][ELEM_W-1:0]         a_col, b_bc;
    logic [DIM-1:0][DIM-1:0][ACC_W-1:0] acc_cols;
    logic [CELLS-1:0][ACC_W-1:0]        c_q;
    logic                               done_q;

    mm2_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctrl  (ctrl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
        end else if (ctrl.load) begin
            a_q <= a_flat;
            b_q <= b_flat;
        end
    end

    mm2_operand_sel u_sel (
        .a_m   (a_q),
        .b_m   (b_q),
        .k     (ctrl.k),
        .a_col (a_col),
        .b_bc  (b_bc)
    );

    for (genvar j = 0; j < DIM; j++) begin : g_col
        mm2_lane_mac u_mac (
            .clk   (clk),
            .rst   (rst),
            .clear (ctrl.load),
            .en    (ctrl.step),
            .vec   (a_col),
            .bscal (elem_t'(b_bc[j])),
            .acc   (acc_cols[j])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= ctrl.fin;
            if (ctrl.fin) begin
                for (int j = 0; j < DIM; j++)
                    for (int i = 0; i < DIM; i++)
                        c_q[cm_idx(i, j)] <= acc_cols[j][i];
            end
        end
    end

    assign c_flat = c_q;
    assign done   = done_q;

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_follows_fin_R4: assert property (@(posedge clk) disable iff (rst)
        ctrl.fin |=> done);

    assert_operands_held_R6: assert property (@(posedge clk) disable iff (rst)
        !ctrl.load |=> ($stable(a_q) && $stable(b_q)));

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !ctrl.fin |=> $stable(c_q));
endmodule

// File: tb/mm2_bcast_engine_tb.sv
module mm2_bcast_engine_tb_top;
    import mm2_pkg::*;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    start = 1'b0;
    logic [CELLS*ELEM_W-1:0] a_flat = '0;
    logic [CELLS*ELEM_W-1:0] b_flat = '0;
    logic [CELLS*ACC_W-1:0]  c_flat;
    logic                    done;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #5ns clk = ~clk;

    mm2_bcast_engine dut_i (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .a_flat (a_flat),
        .b_flat (b_flat),
        .c_flat (c_flat),
        .done   (done)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [CELLS*ELEM_W-1:0] pack(input int v[4]);
        logic [CELLS*ELEM_W-1:0] f;
        for (int i = 0; i < 4; i++) f[i*ELEM_W +: ELEM_W] = v[i][ELEM_W-1:0];
        return f;
    endfunction

    // reference triple loop, column-major index = col*2 + row
    function automatic longint ref_c(input int a[4], input int b[4], input int r, input int c);
        longint s = 0;
        for (int k = 0; k < 2; k++) s += longint'(a[k*2 + r]) * longint'(b[c*2 + k]);
        return s;
    endfunction

    task automatic check_result(input string req, input int a[4], input int b[4]);
        for (int c = 0; c < 2; c++) begin
            for (int r = 0; r < 2; r++) begin
                longint e = ref_c(a, b, r, c);
                chk(req, {30'b0, c_flat[(c*2 + r)*ACC_W +: ACC_W]}, {30'b0, e[ACC_W-1:0]});
            end
        end
    endtask

    task automatic run_mat(input int a[4], input int b[4], input bit disturb, input string req);
        @(negedge clk);
        a_flat = pack(a);
        b_flat = pack(b);
        start  = 1'b1;
        @(negedge clk);                       // after accepting edge E
        start = 1'b0;
        chk({req, " R4 done low E"}, 64'(done), 64'd0);
        @(negedge clk);                       // after E+1
        chk({req, " R4 done low E+1"}, 64'(done), 64'd0);
        if (disturb) begin
            start  = 1'b1;                    // R5: sampled at E+2 and E+3
            a_flat = ~a_flat;                 // R6: live port change
            b_flat = ~b_flat;
        end
        @(negedge clk);                       // after E+2
        chk({req, " R4 done low E+2"}, 64'(done), 64'd0);
        @(negedge clk);                       // after E+3
        start = 1'b0;
        chk({req, " R4 done high"}, 64'(done), 64'd1);
        check_result({req, disturb ? " R5 R6" : " R1 R2"}, a, b);
        @(negedge clk);
        chk({req, disturb ? " R5 no extra done" : " R4 single pulse"}, 64'(done), 64'd0);
        check_result({req, " R9 hold"}, a, b);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int a[4];
        int b[4];
        logic [31:0] t;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R7 done after reset", 64'(done), 64'd0);
        for (int i = 0; i < CELLS; i++)
            chk("R7 result after reset", {30'b0, c_flat[i*ACC_W +: ACC_W]}, 64'd0);

        // R8 worked example
        a = '{1, 0, 0, 1};
        b = '{1, 2, 3, 4};
        run_mat(a, b, 1'b0, "R8");
        for (int i = 0; i < 4; i++)
            chk("R8 packed value", {30'b0, c_flat[i*ACC_W +: ACC_W]}, 64'(i + 1));

        // R1 placement sweep: one nonzero in A, one nonzero in B
        for (int pa = 0; pa < 4; pa++) begin
            for (int pb = 0; pb < 4; pb++) begin
                a = '{0, 0, 0, 0};
                b = '{0, 0, 0, 0};
                a[pa] = 3 + pa;
                b[pb] = -5 - pb;
                run_mat(a, b, 1'b0, "R1 sweep");
            end
        end

        // R3 signed extremes
        a = '{-32768, -32768, -32768, -32768};
        b = '{-32768, -32768, -32768, -32768};
        run_mat(a, b, 1'b0, "R3 min*min");
        a = '{-32768, 32767, -32768, 32767};
        b = '{32767, -32768, 32767, -32768};
        run_mat(a, b, 1'b0, "R3 mixed extremes");
        a = '{32767, 32767, 32767, 32767};
        b = '{32767, 32767, 32767, 32767};
        run_mat(a, b, 1'b1, "R3 max disturbed");

        // R2 R3 random operands, back to back, some disturbed
        for (int n = 0; n < 150; n++) begin
            for (int i = 0; i < 4; i++) begin
                t = $urandom;
                a[i] = int'($signed(t[15:0]));
                t = $urandom;
                b[i] = int'($signed(t[15:0]));
            end
            run_mat(a, b, (n % 3) == 0, "R2 R3 random");
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule